// File: doc/BRIEF.md
# Stereo limiter gain controller

This block watches a stereo stream of signed output samples and lowers a single volume code that both channels share whenever either channel's level reaches a selectable limit. How far the louder channel overshoots decides the size of each cut. The cut either applies at once or waits for both channels to cross zero, which avoids audible steps. The wait ends early after a fixed number of samples.

Each accepted sample produces, one clock later, a registered decision. That decision is an update pulse with the new volume code and a flag telling the gain stage whether to apply it at once or at zero crossings. A separate pulse tells the external recovery logic to restart its hold counter when the level sits just under the limit. This block does not apply the gain to the audio and does not raise the volume.

Samples arrive `DATA_W + 2` bits wide, before saturation, so the block can see overshoot beyond full scale. All levels below are linear magnitudes. They are given in thousandths of the full-scale magnitude FS = 2^(DATA_W-1), and the product is truncated to an integer.

Top module: `stereo_limiter`

## Requirements
- R1: While `rst_ni` is low, `vol_o` equals `VOL_RST` and `upd_o`, `imm_o` and `rcr_o` are 0.
- R2: A sample with `vld_i=1` and `en_i=1` is over the limit when the larger of the two channel magnitudes is at least the limit selected by `thr_sel_i`. The limits are 00: 750, 01: 624, 10: 501 and 11: 376 thousandths of FS. An over-limit sample lowers the shared volume unless R7, R8 or R9 blocks it.
- R3: `rcr_o` pulses for a sample with `en_i=1` when the peak is below the selected limit and at or above the next level down. For select codes 00 to 11 that lower level is 624, 501, 376 and 251 thousandths of FS. `rcr_o` never pulses together with `upd_o`.
- R4: For a deferred cut, the size in volume codes depends on `step_sel_i` and on the highest band the peak reaches. The bands are: the limit, FS (1000), FS+6 dB (1995) and FS+12 dB (3981). Code 00 gives 1,1,1,1. Code 01 gives 2,2,2,2. Code 10 gives 2,4,4,8. Code 11 gives 1,2,4,8.
- R5: With `zc_off_i=1`, each cut is exactly 1 code and `imm_o=1`, whatever `step_sel_i` selects.
- R6: With `zc_off_i=0`, `fs_fast_i=1` and a peak of at least FS, the cut is exactly 1 code and `imm_o=1`.
- R7: Every other cut is deferred (`imm_o=0`). While a deferred cut is pending, no further cut is issued. The cut stops pending after a later valid sample at which both channels have changed sign at least once since the cut, or after `TMO_SAMPLES` valid samples, whichever comes first. A sign change means the sign bit differs from that channel's previous valid sample.
- R8: The volume saturates at 0 and never wraps. When the volume is 0, no update is issued.
- R9: While `en_i=0`, no update or `rcr_o` pulse is issued and any pending deferred cut is dropped.
- R10: Outputs follow a valid sample by one clock. `upd_o` and `rcr_o` are one-cycle pulses, and `vol_o` holds its value except on an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Limiter enable |
| vld_i | input | 1 | Sample strobe |
| left_i | input | DATA_W+2 | Left sample, signed, before saturation |
| right_i | input | DATA_W+2 | Right sample, signed, before saturation |
| thr_sel_i | input | 2 | Limit select |
| step_sel_i | input | 2 | Step table select |
| fs_fast_i | input | 1 | Cut at once on full-scale overshoot |
| zc_off_i | input | 1 | Disable zero-cross deferral |
| vol_o | output | VOL_W | Requested shared volume code |
| upd_o | output | 1 | New volume request pulse |
| imm_o | output | 1 | 1 = apply at once, 0 = at zero crossings |
| rcr_o | output | 1 | Recovery counter reset pulse |

## Verification
The bench builds the block with `DATA_W=8`, `VOL_W=5`, `VOL_RST=31` and `TMO_SAMPLES=6`. In this configuration FS is 128 and the widest input magnitude is 512. A sweep of every magnitude from 0 to 512 can then cover all four limits and all four step tables, together with every band and every edge of the recovery band. A volume of 31 can be driven to its floor, and the six-sample timeout can expire, within a few dozen samples. A long pseudo-random run then mixes configurations, enable gaps and sign patterns, so that blocking, zero-cross release and timeout release interact.

// File: rtl/stereo_limiter_pkg.sv
package stereo_limiter_pkg;

  typedef enum logic [1:0] {
    BAND_THR  = 2'd0,
    BAND_FS   = 2'd1,
    BAND_FS6  = 2'd2,
    BAND_FS12 = 2'd3
  } band_e;

  // Linear level: thousandths of 2^fs_log2, truncated.
  function automatic longint unsigned lvl(input int unsigned fs_log2, input int unsigned permille);
    return ((64'd1 << fs_log2) * 64'(permille)) / 64'd1000;
  endfunction

  function automatic logic [3:0] step_lut(input logic [1:0] sel, input band_e b);
    logic [3:0] s;
    unique case (sel)
      2'b00:   s = 4'd1;
      2'b01:   s = 4'd2;
      2'b10:   s = (b == BAND_THR) ? 4'd2 : ((b == BAND_FS12) ? 4'd8 : 4'd4);
      default: s = 4'd1 << b;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/stereo_limiter_detect.sv
module stereo_limiter_detect
  import stereo_limiter_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic [1:0][DATA_W+1:0] samp_i,
  input  logic [1:0]             thr_sel_i,
  output logic                   hit_o,
  output logic                   near_o,
  output logic                   ge_fs_o,
  output band_e                  band_o
);
  localparam int MW = DATA_W + 2;
  localparam int FL = DATA_W - 1;
  localparam logic [MW-1:0] L_251  = MW'(lvl(FL, 251));
  localparam logic [MW-1:0] L_376  = MW'(lvl(FL, 376));
  localparam logic [MW-1:0] L_501  = MW'(lvl(FL, 501));
  localparam logic [MW-1:0] L_624  = MW'(lvl(FL, 624));
  localparam logic [MW-1:0] L_750  = MW'(lvl(FL, 750));
  localparam logic [MW-1:0] L_FS   = MW'(lvl(FL, 1000));
  localparam logic [MW-1:0] L_FS6  = MW'(lvl(FL, 1995));
  localparam logic [MW-1:0] L_FS12 = MW'(lvl(FL, 3981));
  localparam logic [3:0][MW-1:0] HI_TAB = {L_376, L_501, L_624, L_750};
  localparam logic [3:0][MW-1:0] LO_TAB = {L_251, L_376, L_501, L_624};

  logic [1:0][MW-1:0] mag;
  logic [MW-1:0]      peak;
  logic               ge6, ge12;

  for (genvar ch = 0; ch < 2; ch++) begin : g_abs
    // -2^(MW-1) maps to 2^(MW-1), which still fits unsigned
    assign mag[ch] = samp_i[ch][MW-1] ? (~samp_i[ch] + 1'b1) : samp_i[ch];
  end

  assign peak    = (mag[0] > mag[1]) ? mag[0] : mag[1];
  assign hit_o   = peak >= HI_TAB[thr_sel_i];
  assign near_o  = !hit_o && (peak >= LO_TAB[thr_sel_i]);
  assign ge_fs_o = peak >= L_FS;
  assign ge6     = peak >= L_FS6;
  assign ge12    = peak >= L_FS12;

  always_comb begin
    if (ge12)         band_o = BAND_FS12;
    else if (ge6)     band_o = BAND_FS6;
    else if (ge_fs_o) band_o = BAND_FS;
    else              band_o = BAND_THR;
  end

endmodule

// File: rtl/stereo_limiter_step.sv
module stereo_limiter_step
  import stereo_limiter_pkg::*;
(
  input  band_e       band_i,
  input  logic        ge_fs_i,
  input  logic [1:0]  step_sel_i,
  input  logic        fs_fast_i,
  input  logic        zc_off_i,
  output logic [3:0]  step_o,
  output logic        imm_o
);
  always_comb begin
    if (zc_off_i || (fs_fast_i && ge_fs_i)) begin
      step_o = 4'd1;
      imm_o  = 1'b1;
    end else begin
      step_o = step_lut(step_sel_i, band_i);
      imm_o  = 1'b0;
    end
  end

endmodule

// File: rtl/stereo_limiter_defer.sv
module stereo_limiter_defer #(
  parameter int TMO_SAMPLES = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       vld_i,
  input  logic [1:0] sign_i,
  input  logic       arm_i,
  output logic       pend_o
);
  localparam int CNT_W = $clog2(TMO_SAMPLES + 1);

  logic [1:0]       prev_q, zc_q, zc_n;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign zc_n   = zc_q | (sign_i ^ prev_q);
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      zc_q   <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (vld_i) prev_q <= sign_i;
      if (!en_i) begin
        pend_q <= 1'b0;
      end else if (vld_i) begin
        if (arm_i) begin
          pend_q <= 1'b1;
          zc_q   <= '0;
          cnt_q  <= '0;
        end else if (pend_q) begin
          zc_q  <= zc_n;
          cnt_q <= cnt_q + 1'b1;
          if ((&zc_n) || ((cnt_q + 1'b1) == CNT_W'(TMO_SAMPLES))) pend_q <= 1'b0;
        end
      end
    end
  end

  p_tmo_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (cnt_q < CNT_W'(TMO_SAMPLES)));
  p_arm_when_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |-> !pend_q);
  p_en_drops_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pend_q);

endmodule

// File: rtl/stereo_limiter.sv
module stereo_limiter
  import stereo_limiter_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int VOL_W       = 8,
  parameter int VOL_RST     = 255,
  parameter int TMO_SAMPLES = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                vld_i,
  input  logic [DATA_W+1:0]   left_i,
  input  logic [DATA_W+1:0]   right_i,
  input  logic [1:0]          thr_sel_i,
  input  logic [1:0]          step_sel_i,
  input  logic                fs_fast_i,
  input  logic                zc_off_i,
  output logic [VOL_W-1:0]    vol_o,
  output logic                upd_o,
  output logic                imm_o,
  output logic                rcr_o
);
  localparam int SW = DATA_W + 2;
  localparam int XW = VOL_W + 4;

  logic [1:0][SW-1:0] samp;
  logic               hit, near, ge_fs, imm, pend, issue;
  band_e              band;
  logic [3:0]         step;
  logic [XW-1:0]      vol_x, step_x;
  logic [VOL_W-1:0]   vol_q, vol_nxt;
  logic               upd_q, imm_q, rcr_q;

  assign samp = {right_i, left_i};

  stereo_limiter_detect #(.DATA_W(DATA_W)) u_detect (
    .samp_i   (samp),
    .thr_sel_i(thr_sel_i),
    .hit_o    (hit),
    .near_o   (near),
    .ge_fs_o  (ge_fs),
    .band_o   (band)
  );

  stereo_limiter_step u_step (
    .band_i    (band),
    .ge_fs_i   (ge_fs),
    .step_sel_i(step_sel_i),
    .fs_fast_i (fs_fast_i),
    .zc_off_i  (zc_off_i),
    .step_o    (step),
    .imm_o     (imm)
  );

  stereo_limiter_defer #(.TMO_SAMPLES(TMO_SAMPLES)) u_defer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .vld_i (vld_i),
    .sign_i({right_i[SW-1], left_i[SW-1]}),
    .arm_i (issue && !imm),
    .pend_o(pend)
  );

  assign issue   = vld_i && en_i && hit && !pend && (vol_q != '0);
  assign vol_x   = XW'(vol_q);
  assign step_x  = XW'(step);
  // saturate at the floor code
  assign vol_nxt = (vol_x >= step_x) ? VOL_W'(vol_x - step_x) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q <= VOL_W'(VOL_RST);
      upd_q <= 1'b0;
      imm_q <= 1'b0;
      rcr_q <= 1'b0;
    end else begin
      upd_q <= issue;
      imm_q <= issue && imm;
      rcr_q <= vld_i && en_i && near;
      if (issue) vol_q <= vol_nxt;
    end
  end

  assign vol_o = vol_q;
  assign upd_o = upd_q;
  assign imm_o = imm_q;
  assign rcr_o = rcr_q;

  p_upd_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(vld_i && en_i));
  p_rcr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rcr_o && upd_o));
  p_band_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band != BAND_THR) |-> (ge_fs && hit));
  p_imm_unit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && imm_o) |-> ($past(vol_o) == vol_o + 1'b1));
  p_vol_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (vol_o < $past(vol_o)));
  p_vol_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(vol_o));

endmodule

// File: tb/stereo_limiter_test.sv
module stereo_limiter_test;
  localparam int DW  = 8;
  localparam int VW  = 5;
  localparam int VR  = 31;
  localparam int TMO = 6;
  localparam int SW  = DW + 2;
  localparam int FS  = 1 << (DW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, vld = 1'b0, fsf = 1'b0, zco = 1'b0;
  logic [SW-1:0] left = '0, right = '0;
  logic [1:0] thr = 2'd0, stp = 2'd0;
  logic [VW-1:0] vol;
  logic upd, imm, rcr;

  int n_tot = 0, n_bad = 0;
  int m_vol, m_cnt;
  bit m_pend, m_zl, m_zr, m_pl, m_pr;
  int e_upd, e_imm, e_rcr;
  logic [31:0] rng = 32'h1ace_b00c;

  always #4 clk = ~clk;

  stereo_limiter #(.DATA_W(DW), .VOL_W(VW), .VOL_RST(VR), .TMO_SAMPLES(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .vld_i(vld),
    .left_i(left), .right_i(right), .thr_sel_i(thr), .step_sel_i(stp),
    .fs_fast_i(fsf), .zc_off_i(zco),
    .vol_o(vol), .upd_o(upd), .imm_o(imm), .rcr_o(rcr)
  );

  function automatic int lv(input int pm);
    return (FS * pm) / 1000;
  endfunction

  function automatic int hi_lim(input int s);
    case (s)
      0: return lv(750);
      1: return lv(624);
      2: return lv(501);
      default: return lv(376);
    endcase
  endfunction

  function automatic int lo_lim(input int s);
    case (s)
      0: return lv(624);
      1: return lv(501);
      2: return lv(376);
      default: return lv(251);
    endcase
  endfunction

  function automatic int tab(input int s, input int b);
    case (s)
      0: return 1;
      1: return 2;
      2: return (b == 0) ? 2 : ((b == 3) ? 8 : 4);
      default: return 1 << b;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_init();
    m_vol = VR; m_pend = 0; m_zl = 0; m_zr = 0; m_pl = 0; m_pr = 0; m_cnt = 0;
    e_upd = 0; e_imm = 0; e_rcr = 0;
  endtask

  task automatic do_reset();
    vld = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 vol", int'(vol), VR);
    chk("R1 upd", int'(upd), 0);
    chk("R1 imm", int'(imm), 0);
    chk("R1 rcr", int'(rcr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_init();
  endtask

  task automatic put(input int sl, input int sr);
    int ml, mr, pk, b, st;
    bit hit, ge_fs, immx;
    string ctx;
    left = SW'(sl); right = SW'(sr); vld = 1'b1;
    ml = (sl < 0) ? -sl : sl;
    mr = (sr < 0) ? -sr : sr;
    pk = (ml > mr) ? ml : mr;
    hit = pk >= hi_lim(thr);
    ge_fs = pk >= FS;
    b = (pk >= lv(3981)) ? 3 : (pk >= lv(1995)) ? 2 : ge_fs ? 1 : 0;
    e_rcr = (en && !hit && pk >= lo_lim(thr)) ? 1 : 0;
    e_upd = 0; e_imm = 0; ctx = "R2";
    if (!en) begin
      m_pend = 0; ctx = "R9";
    end else if (hit && !m_pend && m_vol != 0) begin
      if (zco) begin st = 1; immx = 1; ctx = "R5"; end
      else if (fsf && ge_fs) begin st = 1; immx = 1; ctx = "R6"; end
      else begin st = tab(stp, b); immx = 0; ctx = "R4"; end
      m_vol = (m_vol >= st) ? m_vol - st : 0;
      e_upd = 1; e_imm = immx;
      if (!immx) begin m_pend = 1; m_zl = 0; m_zr = 0; m_cnt = 0; end
    end else if (m_pend) begin
      if (hit) ctx = "R7";
      m_zl = m_zl | ((sl < 0) != m_pl);
      m_zr = m_zr | ((sr < 0) != m_pr);
      m_cnt++;
      if ((m_zl && m_zr) || m_cnt == TMO) m_pend = 0;
    end else if (hit && m_vol == 0) begin
      ctx = "R8";
    end
    m_pl = sl < 0; m_pr = sr < 0;
    @(negedge clk);
    chk({ctx, " upd"}, int'(upd), e_upd);
    chk({ctx, " imm"}, int'(imm), e_imm);
    chk({ctx, " vol"}, int'(vol), m_vol);
    chk("R3 rcr", int'(rcr), e_rcr);
  endtask

  task automatic idle();
    vld = 1'b0;
    @(negedge clk);
    chk("R10 upd pulse", int'(upd), 0);
    chk("R10 rcr pulse", int'(rcr), 0);
    chk("R10 vol hold", int'(vol), m_vol);
  endtask

  function automatic logic [31:0] step_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R8: drive volume to floor with unit immediate cuts, then no more updates
    en = 1'b1; zco = 1'b1; thr = 2'd0;
    for (int i = 0; i < VR + 3; i++) put(110, -20);
    idle();
    // R7: deferred cut, no sign changes -> released by timeout only
    do_reset();
    en = 1'b1; zco = 1'b0; fsf = 1'b0; stp = 2'd3;
    for (int i = 0; i < 3 * TMO; i++) put(300, 5);
    idle();
    // R7: release by zero crossings on both channels
    do_reset();
    for (int i = 0; i < 12; i++) put(((i % 2) != 0) ? -200 : 200, ((i % 3) != 0) ? -3 : 3);
    // R9: enable low drops pending and suppresses outputs
    put(480, 0);
    en = 1'b0;
    put(480, 0);
    put(90, 90);
    en = 1'b1;
    put(480, 0);
    idle();
    // R6: full-scale fast path
    do_reset();
    fsf = 1'b1; stp = 2'd2;
    put(130, 0); put(-511, 3); put(100, 0); idle();

    // sweep: every magnitude for every limit and step table
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 4; s++) begin
        for (int m = 0; m <= 512; m++) begin
          int v, o;
          do_reset();
          en = 1'b1; thr = 2'(t); stp = 2'(s);
          zco = m[0]; fsf = m[1];
          v = m[2] ? -m : m;
          if (m == 512) v = -512;
          o = (v < 0) ? (m / 2) : -(m / 2);
          if (m[3]) put(v, o); else put(o, v);
          put(-1, -1);
          put(1, 1);
        end
      end
    end

    // pseudo-random mixed stream
    do_reset();
    en = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      int sl, sr;
      if (i % 400 == 399) do_reset();
      if (i % 37 == 0) begin
        rng = step_rng(rng);
        thr = rng[1:0]; stp = rng[3:2]; fsf = rng[4];
        zco = (rng[7:5] == 3'd0);
        en = (rng[11:8] != 4'd0);
      end
      rng = step_rng(rng);
      sl = int'($signed(rng[SW-1:0]));
      sr = int'($signed(rng[SW+9:10]));
      if (rng[28]) sl = sl / 4;
      if (rng[29]) sr = sr / 8;
      put(sl, sr);
      if (rng[31:27] == 5'd0) idle();
    end

    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule